// File: doc/BRIEF.md
# Synchronized multi-channel clock divider

This block takes one fast clock, assumed to be already pre-divided upstream, and derives five divided clock waveforms from it. Each channel has its own start delay and its own divide ratio. All channels restart together from one sync event, so their waveforms keep a fixed phase relation to each other. The only offsets between them are the delays that were programmed.

A sync request comes from an external pin or from a software control bit, and the two are ORed together. While the request is high, every output is held low. The sync event is the falling edge of the request, taken after a two-flop synchroniser. At that event each channel captures its delay and ratio, counts out the delay and then starts with a rising edge. When the reference-aligned mode input is set, channel 0 ignores its delay. The block then starts it at a fixed, known latency after the sync request falls.

Configuration arrives on plain parallel inputs. No data stream flows through the block, so no port uses a valid/ready handshake. A single `busy` status output shows that a sync is in progress.

Top module: `sync_clk_divider`

## Requirements
- R1: After reset, all five outputs `clk_out` and `busy` are low, and every channel stays low until the first sync event.
- R2: The sync request is `sync_pin | sw_sync`. Its falling edge is the sync event. If the request is driven low before rising clock edge 1, an enabled channel with zero delay is first high after edge 4.
- R3: Once the request has been high for 3 rising edges, every output is low for as long as the request stays high.
- R4: A channel with delay field D (bits [8i+7:8i] of `ch_delay`, 0 to 255) has its first rising edge D cycles later than it would with D = 0, which is after edge 4+D.
- R5: A channel with ratio field N (bits [10i+9:10i] of `ch_ratio`, 1 to 512) repeats a period of N cycles. It is high for floor(N/2)+1 cycles when N is odd and N/2 cycles when N is even, and low for the rest of the period. N = 1 gives a constant high. A field value of 0 acts as 1.
- R6: All channels that take part in one sync start their periods on the same cycle, apart from their own delays.
- R7: When `ref_align` is 1 at the sync event, channel 0 starts as if its delay were 0. The other channels still use their delays.
- R8: Delay, ratio and `ref_align` are captured only at the sync event. Changing them at any other time does not change the outputs until the next sync.
- R9: When `ch_en[i]` is low, `clk_out[i]` is low from the next cycle on. A channel that is re-enabled and then synced again runs aligned with the others.
- R10: `busy` is high after edge 3+Dmax and low after edge 4+Dmax, where Dmax is the largest effective delay among the enabled channels and the request is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pre-divided fast input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_pin | input | 1 | External sync request, asynchronous |
| sw_sync | input | 1 | Software sync request bit |
| ref_align | input | 1 | Reference-aligned mode: channel 0 skips its delay |
| ch_en | input | 5 | Per-channel enable |
| ch_delay | input | 40 | Per-channel start delay, 8 bits each |
| ch_ratio | input | 50 | Per-channel divide ratio, 10 bits each |
| clk_out | output | 5 | Divided clock outputs |
| busy | output | 1 | Sync in progress |

## Verification
The first pattern uses zero delays with ratios 1 to 5. It separates the odd and even duty-cycle rules and shows whether the five channels share one start cycle. The second pattern uses extreme settings: delay 255 and ratio 512 next to ratio 1 and small odd ratios. It exposes counter width and terminal-count errors and fixes the point at which `busy` falls.

Reference-aligned mode is tried with the same delay on channels 0 and 1, so a skip that leaks to other channels shows up. Two further runs change the configuration without a sync and then disable and re-enable a channel. These tell sampling at the sync event apart from live use of the inputs, and check that a channel rejoins the others in phase.

// File: rtl/sync_clk_divider_pkg.sv
package sync_clk_divider_pkg;
  typedef enum logic [1:0] {
    CH_HOLD  = 2'd0,
    CH_DELAY = 2'd1,
    CH_RUN   = 2'd2
  } ch_state_t;
endpackage

// File: rtl/scd_sync_detect.sv
module scd_sync_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async,
  output logic req_lvl,
  output logic sync_pulse,
  output logic sync_busy
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q       <= 1'b0;
      s2_q       <= 1'b0;
      s3_q       <= 1'b0;
      sync_pulse <= 1'b0;
    end else begin
      s1_q       <= req_async;
      s2_q       <= s1_q;
      s3_q       <= s2_q;
      sync_pulse <= s3_q & ~s2_q;
    end
  end

  assign req_lvl   = s2_q;
  assign sync_busy = s2_q | s3_q | sync_pulse;
endmodule

// File: rtl/scd_channel.sv
module scd_channel
  import sync_clk_divider_pkg::*;
#(
  parameter int DLY_W   = 8,
  parameter int DIV_W   = 10,
  parameter int MAX_DIV = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hold,
  input  logic             start,
  input  logic             skip_dly,
  input  logic [DLY_W-1:0] dly_in,
  input  logic [DIV_W-1:0] ratio_in,
  output logic             out,
  output logic             in_delay
);
  localparam logic [DIV_W-1:0] MAXR = DIV_W'(MAX_DIV);

  ch_state_t        st;
  logic [DIV_W-1:0] r_eff, last_q, hi_q, pcnt, pnxt;
  logic [DLY_W-1:0] d_eff, dcnt;

  always_comb begin
    if (ratio_in == '0)      r_eff = DIV_W'(1);
    else if (ratio_in > MAXR) r_eff = MAXR;
    else                      r_eff = ratio_in;
    d_eff = skip_dly ? '0 : dly_in;
    pnxt  = (pcnt == last_q) ? '0 : pcnt + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= CH_HOLD;
      out    <= 1'b0;
      dcnt   <= '0;
      pcnt   <= '0;
      last_q <= '0;
      hi_q   <= DIV_W'(1);
    end else if (!en || hold) begin
      st  <= CH_HOLD;
      out <= 1'b0;
    end else if (start) begin
      last_q <= r_eff - DIV_W'(1);
      hi_q   <= (r_eff + DIV_W'(1)) >> 1;
      pcnt   <= '0;
      if (d_eff == '0) begin
        st  <= CH_RUN;
        out <= 1'b1;
      end else begin
        st   <= CH_DELAY;
        dcnt <= d_eff;
        out  <= 1'b0;
      end
    end else begin
      case (st)
        CH_DELAY: begin
          if (dcnt == DLY_W'(1)) begin
            st   <= CH_RUN;
            pcnt <= '0;
            out  <= 1'b1;
          end else begin
            dcnt <= dcnt - DLY_W'(1);
          end
        end
        CH_RUN: begin
          pcnt <= pnxt;
          out  <= (pnxt < hi_q);
        end
        default: out <= 1'b0;
      endcase
    end
  end

  assign in_delay = (st == CH_DELAY);
endmodule

// File: rtl/sync_clk_divider.sv
module sync_clk_divider #(
  parameter int NUM_CH  = 5,
  parameter int DLY_W   = 8,
  parameter int DIV_W   = 10,
  parameter int MAX_DIV = 512
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sync_pin,
  input  logic                    sw_sync,
  input  logic                    ref_align,
  input  logic [NUM_CH-1:0]       ch_en,
  input  logic [NUM_CH*DLY_W-1:0] ch_delay,
  input  logic [NUM_CH*DIV_W-1:0] ch_ratio,
  output logic [NUM_CH-1:0]       clk_out,
  output logic                    busy
);
  logic              req_lvl, sync_pulse, sync_busy;
  logic [NUM_CH-1:0] in_dly;

  scd_sync_detect u_det (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_async  (sync_pin | sw_sync),
    .req_lvl    (req_lvl),
    .sync_pulse (sync_pulse),
    .sync_busy  (sync_busy)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    scd_channel #(
      .DLY_W   (DLY_W),
      .DIV_W   (DIV_W),
      .MAX_DIV (MAX_DIV)
    ) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ch_en[i]),
      .hold     (req_lvl),
      .start    (sync_pulse),
      .skip_dly ((i == 0) ? ref_align : 1'b0),
      .dly_in   (ch_delay[i*DLY_W +: DLY_W]),
      .ratio_in (ch_ratio[i*DIV_W +: DIV_W]),
      .out      (clk_out[i]),
      .in_delay (in_dly[i])
    );
  end

  assign busy = sync_busy | (|in_dly);
endmodule

// File: rtl/sync_clk_divider_chk.sv
module sync_clk_divider_chk #(
  parameter int NUM_CH = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_align,
  input logic [NUM_CH-1:0] ch_en,
  input logic [NUM_CH-1:0] clk_out,
  input logic              req_lvl,
  input logic              sync_pulse
);
  // R2
  sync_event_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_lvl) |=> sync_pulse);

  // R2
  sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> !sync_pulse);

  // R3
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_lvl |=> (clk_out == '0));

  // R7
  ref_align_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pulse && ref_align && ch_en[0]) |=> clk_out[0]);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_en
    // R9
    disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[g] |=> !clk_out[g]);
  end
endmodule

bind sync_clk_divider sync_clk_divider_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_align  (ref_align),
  .ch_en      (ch_en),
  .clk_out    (clk_out),
  .req_lvl    (req_lvl),
  .sync_pulse (sync_pulse)
);

// File: tb/sync_clk_divider_tb.sv
module sync_clk_divider_tb;
  localparam int CLK_P = 10;
  localparam int NCH   = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sync_pin = 1'b0;
  logic             sw_sync = 1'b0;
  logic             ref_align = 1'b0;
  logic [NCH-1:0]   ch_en = '1;
  logic [NCH*8-1:0] ch_delay = '0;
  logic [NCH*10-1:0] ch_ratio = '0;
  logic [NCH-1:0]   clk_out;
  logic             busy;

  int n_chk = 0;
  int n_fail = 0;
  int d_m[NCH];
  int n_m[NCH];
  bit en_m[NCH];
  bit ra_m;

  always #(CLK_P/2) clk = ~clk;

  sync_clk_divider u_dut (
    .clk(clk), .rst_n(rst_n), .sync_pin(sync_pin), .sw_sync(sw_sync),
    .ref_align(ref_align), .ch_en(ch_en), .ch_delay(ch_delay),
    .ch_ratio(ch_ratio), .clk_out(clk_out), .busy(busy)
  );

  function automatic int eff_dly(int i);
    return (i == 0 && ra_m) ? 0 : d_m[i];
  endfunction

  function automatic bit exp_out(int i, int j);
    int d, c;
    if (!en_m[i]) return 1'b0;
    d = eff_dly(i);
    if (j < 4 + d) return 1'b0;
    c = (j - 4 - d) % n_m[i];
    return c < (n_m[i] + 1) / 2;
  endfunction

  task automatic set_ch(int i, int dly, int ratio);
    ch_delay[i*8 +: 8]   = 8'(dly);
    ch_ratio[i*10 +: 10] = 10'(ratio);
  endtask

  // Latches the model at a sync event, then drives the request high and low.
  task automatic do_sync(bit use_sw, string tag);
    @(negedge clk);
    for (int i = 0; i < NCH; i++) begin
      d_m[i]  = int'(ch_delay[i*8 +: 8]);
      n_m[i]  = (ch_ratio[i*10 +: 10] == 0) ? 1 : int'(ch_ratio[i*10 +: 10]);
      en_m[i] = ch_en[i];
    end
    ra_m = ref_align;
    if (use_sw) sw_sync = 1'b1; else sync_pin = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (clk_out !== '0) begin
      n_fail++;
      $display("FAIL R3 %s: outputs during sync actual=%b expected=00000", tag, clk_out);
    end
    sync_pin = 1'b0;
    sw_sync  = 1'b0;
  endtask

  // Compares every channel, and busy at its edges, over cycles j0..j0+len-1 after the fall.
  task automatic check_window(string tag, int j0, int len);
    int bad[NCH];
    int first_j[NCH];
    logic a_v[NCH];
    logic e_v[NCH];
    int dmax = 0;
    for (int i = 0; i < NCH; i++) begin
      bad[i] = 0;
      if (en_m[i] && eff_dly(i) > dmax) dmax = eff_dly(i);
    end
    for (int j = j0; j < j0 + len; j++) begin
      @(posedge clk);
      @(negedge clk);
      for (int i = 0; i < NCH; i++) begin
        if (clk_out[i] !== exp_out(i, j)) begin
          if (bad[i] == 0) begin
            first_j[i] = j; a_v[i] = clk_out[i]; e_v[i] = exp_out(i, j);
          end
          bad[i]++;
        end
      end
      if (j == 3 + dmax) begin
        n_chk++;
        if (busy !== 1'b1) begin
          n_fail++;
          $display("FAIL R10 %s: busy at j=%0d actual=%b expected=1", tag, j, busy);
        end
      end
      if (j == 4 + dmax) begin
        n_chk++;
        if (busy !== 1'b0) begin
          n_fail++;
          $display("FAIL R10 %s: busy at j=%0d actual=%b expected=0", tag, j, busy);
        end
      end
    end
    for (int i = 0; i < NCH; i++) begin
      n_chk++;
      if (bad[i] != 0) begin
        n_fail++;
        $display("FAIL %s ch%0d: %0d mismatches, first j=%0d actual=%b expected=%b",
                 tag, i, bad[i], first_j[i], a_v[i], e_v[i]);
      end
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (clk_out !== '0 || busy !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: actual out=%b busy=%b expected out=00000 busy=0", clk_out, busy);
    end
  endtask

  task automatic t_basic;
    for (int i = 0; i < NCH; i++) set_ch(i, 0, i + 1);
    ch_en = '1; ref_align = 1'b0;
    do_sync(1'b0, "R2 pin");
    check_window("R2 R5 R6 basic", 1, 80);
  endtask

  task automatic t_extremes;
    set_ch(0, 0, 512); set_ch(1, 1, 7); set_ch(2, 7, 2);
    set_ch(3, 255, 9); set_ch(4, 100, 0);
    do_sync(1'b0, "R4 ext");
    check_window("R4 R5 R10 extremes", 1, 1300);
  endtask

  task automatic t_ref_align;
    set_ch(0, 10, 4); set_ch(1, 10, 4); set_ch(2, 3, 3);
    set_ch(3, 0, 6); set_ch(4, 20, 5);
    ref_align = 1'b1;
    do_sync(1'b1, "R7 ra");
    check_window("R7 ref_align", 1, 120);
    ref_align = 1'b0;
  endtask

  task automatic t_no_sync_change;
    set_ch(0, 2, 3); set_ch(1, 4, 8); set_ch(2, 0, 1);
    set_ch(3, 6, 5); set_ch(4, 1, 10);
    do_sync(1'b1, "R8 sw");
    check_window("R8 before change", 1, 100);
    for (int i = 0; i < NCH; i++) set_ch(i, 9, 13);
    ref_align = 1'b1;
    check_window("R8 change without sync", 101, 150);
    do_sync(1'b0, "R8 resync");
    check_window("R8 after resync", 1, 120);
    ref_align = 1'b0;
  endtask

  task automatic t_disable;
    for (int i = 0; i < NCH; i++) set_ch(i, i * 2, 6);
    ch_en = '1;
    do_sync(1'b0, "R9 start");
    check_window("R9 all on", 1, 60);
    ch_en[2] = 1'b0; en_m[2] = 1'b0;
    check_window("R9 ch2 off", 61, 60);
    ch_en[2] = 1'b1;
    check_window("R9 ch2 on no sync", 121, 30);
    do_sync(1'b1, "R9 resync");
    check_window("R9 ch2 rejoined", 1, 60);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_extremes();
    t_ref_align();
    t_no_sync_change();
    t_disable();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule